// File: doc/BRIEF.md
# Fabric Clock Source and Enable Sequencer

This block chooses the clock that drives a small programmable logic fabric and decides when that fabric may start working. The clock is picked from a set of candidates by a registered source code: any of the I/O terminals or chip-side terminals, one of three divided clocks (each tagged with the deepest power mode it survives), the low-frequency clock, or the system clock itself for asynchronous operation. After the enable bit is set, the sequencer counts rising edges of the chosen clock and raises the fabric-enable output after two edges, or after three system-clock edges in asynchronous mode.

The block also produces the fabric reset. Power-on reset always drives it. Whether a power-mode entry also drives it depends on the class of the chosen clock. The fabric reset clears only run-time state, which here is the edge counter. The configuration register is cleared only by power-on reset. A configuration error is flagged when the terminal chosen as the clock is also marked as a LUT input in the usage mask, or when the source code is unassigned.

All control and status pins are plain levels. The block moves no data, so it has no handshake.

Top module: `fabric_clk_seq`

## Requirements
- R1: Source codes select the fabric clock as follows: 0–7 I/O terminal n, 8–15 chip terminal n−8, 16 active-class divided clock, 17 deep-sleep-class divided clock, 18 hibernate-class divided clock, 19 low-frequency clock, 20 system clock (asynchronous mode). Codes 21–31 hold `fab_clk` at 0 and raise `cfg_err`.
- R2: For terminal, divided and low-frequency sources, `fab_en` rises on the second rising edge of the selected clock after the enable bit has been registered.
- R3: For code 20, `fab_en` rises on the third `sys_clk` rising edge after the edge that registers the enable bit.
- R4: With a terminal source, the hibernate-class divided clock or asynchronous mode, `fab_rst` is driven by `por` alone. Power-mode changes have no effect.
- R5: With the active-class divided clock, `fab_rst` is also asserted while `pm_mode` is deep-sleep (01) or hibernate (10 or 11).
- R6: With the deep-sleep-class divided clock or the low-frequency clock, `fab_rst` is also asserted while `pm_mode` is hibernate (10 or 11), but not in deep-sleep (01).
- R7: `cfg_err` is high when the selected source is a terminal whose bit is set in the LUT usage mask. Bits 0–7 stand for I/O terminals and bits 8–15 for chip terminals, so bit n matches source code n.
- R8: A power-mode fabric reset keeps the configuration, so the fabric re-enables after the edge count with no new write. `por` clears the configuration to code 0, enable off and mask 0.
- R9: When the enable bit is written to 0, `fab_en` drops at that `sys_clk` edge and `fab_rst` is not asserted. A new enable restarts the edge count from zero.
- R10: Edges of clocks that are not selected do not advance the count. Edges that arrive while `fab_rst` is high do not advance it either, and `fab_en` is low while `fab_rst` is high.
- R11: Configuration inputs are captured only on a `sys_clk` rising edge with `cfg_wr` high. At all other times they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock: configuration register and asynchronous-mode source |
| por | input | 1 | Power-on reset, asynchronous, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 5 | Clock source code |
| cfg_en | input | 1 | Fabric enable bit |
| cfg_lut_mask | input | 16 | Terminals used as LUT inputs (bit n = source code n) |
| pm_mode | input | 2 | Power mode: 00 active, 01 deep-sleep, 1x hibernate |
| io_term | input | 8 | I/O terminal signals |
| chip_term | input | 8 | Chip-side terminal signals |
| div_act_clk | input | 1 | Divided clock, active class |
| div_ds_clk | input | 1 | Divided clock, deep-sleep class |
| div_hib_clk | input | 1 | Divided clock, hibernate class |
| lf_clk | input | 1 | Low-frequency clock |
| fab_clk | output | 1 | Selected fabric clock |
| fab_en | output | 1 | Fabric enable |
| fab_rst | output | 1 | Fabric reset for synchronous state |
| cfg_err | output | 1 | Illegal clock configuration |

## Verification
The hardest situation to reach is a run of edges on the selected clock that arrives while a power mode holds the fabric in reset, followed by a return to active mode, where the count must restart from zero with the configuration still in place. The bench never runs the candidate clocks freely. It produces each edge as a single pulse that starts one nanosecond after a `sys_clk` edge, so it can place edges before, during and after a power-mode window. It also pulses clocks that are not selected, to show that the count does not move.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  typedef enum logic [2:0] {
    CLS_TERM,
    CLS_DIV_ACT,
    CLS_DIV_DS,
    CLS_DIV_HIB,
    CLS_LF,
    CLS_ASYNC,
    CLS_BAD
  } src_class_e;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_DSLEEP = 2'b01,
    PM_HIB    = 2'b10,
    PM_HIB_X  = 2'b11
  } pm_mode_e;

  localparam int unsigned SYNC_EDGES  = 2;
  localparam int unsigned ASYNC_EDGES = 3;
endpackage

// File: rtl/fcs_cfg_reg.sv
`timescale 1ns/1ps
module fcs_cfg_reg #(
  parameter int SRC_W  = 5,
  parameter int MASK_W = 16
) (
  input  logic              sys_clk,
  input  logic              por,
  input  logic              wr,
  input  logic [SRC_W-1:0]  src_in,
  input  logic              en_in,
  input  logic [MASK_W-1:0] mask_in,
  output logic [SRC_W-1:0]  src_q,
  output logic              en_q,
  output logic [MASK_W-1:0] mask_q
);
  always_ff @(posedge sys_clk or posedge por) begin
    if (por) begin
      src_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (wr) begin
      src_q  <= src_in;
      en_q   <= en_in;
      mask_q <= mask_in;
    end
  end
endmodule

// File: rtl/fcs_src_decode.sv
`timescale 1ns/1ps
module fcs_src_decode
  import fcs_pkg::*;
#(
  parameter int N_TERM = 8,
  parameter int SRC_W  = 5
) (
  input  logic [SRC_W-1:0]    src,
  input  logic [2*N_TERM-1:0] mask,
  output src_class_e          cls,
  output logic                err
);
  localparam int TERM_CNT = 2 * N_TERM;
  localparam int IDX_W    = $clog2(TERM_CNT);
  localparam logic [SRC_W-1:0] C_ACT   = SRC_W'(TERM_CNT);
  localparam logic [SRC_W-1:0] C_DS    = SRC_W'(TERM_CNT + 1);
  localparam logic [SRC_W-1:0] C_HIB   = SRC_W'(TERM_CNT + 2);
  localparam logic [SRC_W-1:0] C_LF    = SRC_W'(TERM_CNT + 3);
  localparam logic [SRC_W-1:0] C_ASYNC = SRC_W'(TERM_CNT + 4);

  always_comb begin
    if (src < C_ACT)        cls = CLS_TERM;
    else if (src == C_ACT)  cls = CLS_DIV_ACT;
    else if (src == C_DS)   cls = CLS_DIV_DS;
    else if (src == C_HIB)  cls = CLS_DIV_HIB;
    else if (src == C_LF)   cls = CLS_LF;
    else if (src == C_ASYNC) cls = CLS_ASYNC;
    else                    cls = CLS_BAD;
  end

  always_comb begin
    err = 1'b0;
    if (cls == CLS_BAD) err = 1'b1;
    else if (cls == CLS_TERM) err = mask[src[IDX_W-1:0]];
  end
endmodule

// File: rtl/fcs_clk_mux.sv
`timescale 1ns/1ps
module fcs_clk_mux #(
  parameter int N_TERM = 8,
  parameter int SRC_W  = 5
) (
  input  logic [SRC_W-1:0]  src,
  input  logic [N_TERM-1:0] io_term,
  input  logic [N_TERM-1:0] chip_term,
  input  logic              div_act_clk,
  input  logic              div_ds_clk,
  input  logic              div_hib_clk,
  input  logic              lf_clk,
  input  logic              sys_clk,
  output logic              fab_clk
);
  localparam int NSRC = 2 * N_TERM + 5;
  logic [NSRC-1:0] cand;

  for (genvar g = 0; g < N_TERM; g++) begin : g_term
    assign cand[g]          = io_term[g];
    assign cand[N_TERM + g] = chip_term[g];
  end
  assign cand[2*N_TERM]     = div_act_clk;
  assign cand[2*N_TERM + 1] = div_ds_clk;
  assign cand[2*N_TERM + 2] = div_hib_clk;
  assign cand[2*N_TERM + 3] = lf_clk;
  assign cand[2*N_TERM + 4] = sys_clk;

  always_comb begin
    fab_clk = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src == SRC_W'(i)) fab_clk = cand[i];
    end
  end
endmodule

// File: rtl/fcs_rst_policy.sv
`timescale 1ns/1ps
module fcs_rst_policy
  import fcs_pkg::*;
(
  input  logic       por,
  input  src_class_e cls,
  input  logic [1:0] pm_mode,
  output logic       fab_rst
);
  logic pm_rst;

  always_comb begin
    case (cls)
      CLS_DIV_ACT:      pm_rst = (pm_mode != PM_ACTIVE);
      CLS_DIV_DS,
      CLS_LF:           pm_rst = pm_mode[1];
      default:          pm_rst = 1'b0;
    endcase
  end

  assign fab_rst = por | pm_rst;
endmodule

// File: rtl/fcs_en_seq.sv
`timescale 1ns/1ps
module fcs_en_seq #(
  parameter int CNT_W = 2
) (
  input  logic             fab_clk,
  input  logic             clr,
  input  logic             en_q,
  input  logic [CNT_W-1:0] tgt,
  output logic             fab_en
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge fab_clk or posedge clr) begin
    if (clr) cnt <= '0;
    else if (cnt < tgt) cnt <= cnt + 1'b1;
  end

  assign fab_en = en_q & (cnt >= tgt);
endmodule

// File: rtl/fabric_clk_seq.sv
`timescale 1ns/1ps
module fabric_clk_seq
  import fcs_pkg::*;
#(
  parameter int N_TERM = 8,
  localparam int SRC_W  = $clog2(2 * N_TERM + 5),
  localparam int MASK_W = 2 * N_TERM
) (
  input  logic              sys_clk,
  input  logic              por,
  input  logic              cfg_wr,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic              cfg_en,
  input  logic [MASK_W-1:0] cfg_lut_mask,
  input  logic [1:0]        pm_mode,
  input  logic [N_TERM-1:0] io_term,
  input  logic [N_TERM-1:0] chip_term,
  input  logic              div_act_clk,
  input  logic              div_ds_clk,
  input  logic              div_hib_clk,
  input  logic              lf_clk,
  output logic              fab_clk,
  output logic              fab_en,
  output logic              fab_rst,
  output logic              cfg_err
);
  localparam int CNT_W = $clog2(ASYNC_EDGES + 1);

  logic [SRC_W-1:0]  src_q;
  logic              en_q;
  logic [MASK_W-1:0] mask_q;
  src_class_e        cls;
  logic [CNT_W-1:0]  tgt;
  logic              cnt_clr;

  fcs_cfg_reg #(.SRC_W(SRC_W), .MASK_W(MASK_W)) u_cfg (
    .sys_clk (sys_clk),
    .por     (por),
    .wr      (cfg_wr),
    .src_in  (cfg_src),
    .en_in   (cfg_en),
    .mask_in (cfg_lut_mask),
    .src_q   (src_q),
    .en_q    (en_q),
    .mask_q  (mask_q)
  );

  fcs_src_decode #(.N_TERM(N_TERM), .SRC_W(SRC_W)) u_dec (
    .src  (src_q),
    .mask (mask_q),
    .cls  (cls),
    .err  (cfg_err)
  );

  fcs_clk_mux #(.N_TERM(N_TERM), .SRC_W(SRC_W)) u_mux (
    .src         (src_q),
    .io_term     (io_term),
    .chip_term   (chip_term),
    .div_act_clk (div_act_clk),
    .div_ds_clk  (div_ds_clk),
    .div_hib_clk (div_hib_clk),
    .lf_clk      (lf_clk),
    .sys_clk     (sys_clk),
    .fab_clk     (fab_clk)
  );

  fcs_rst_policy u_rst (
    .por     (por),
    .cls     (cls),
    .pm_mode (pm_mode),
    .fab_rst (fab_rst)
  );

  assign tgt     = (cls == CLS_ASYNC) ? CNT_W'(ASYNC_EDGES) : CNT_W'(SYNC_EDGES);
  assign cnt_clr = fab_rst | ~en_q;

  fcs_en_seq #(.CNT_W(CNT_W)) u_seq (
    .fab_clk (fab_clk),
    .clr     (cnt_clr),
    .en_q    (en_q),
    .tgt     (tgt),
    .fab_en  (fab_en)
  );
endmodule

// File: rtl/fabric_clk_seq_chk.sv
`timescale 1ns/1ps
module fabric_clk_seq_chk #(
  parameter int N_TERM = 8,
  parameter int SRC_W  = 5
) (
  input logic             sys_clk,
  input logic             por,
  input logic             cfg_wr,
  input logic             cfg_en,
  input logic [SRC_W-1:0] src_q,
  input logic [1:0]       pm_mode,
  input logic             fab_clk,
  input logic             fab_en,
  input logic             fab_rst,
  input logic             cfg_err
);
  localparam logic [SRC_W-1:0] K_ACT   = SRC_W'(2 * N_TERM);
  localparam logic [SRC_W-1:0] K_DS    = SRC_W'(2 * N_TERM + 1);
  localparam logic [SRC_W-1:0] K_LF    = SRC_W'(2 * N_TERM + 3);
  localparam logic [SRC_W-1:0] K_ASYNC = SRC_W'(2 * N_TERM + 4);

  assert_bad_code_R1: assert property (@(posedge sys_clk) disable iff (por)
    (src_q > K_ASYNC) |-> (cfg_err && !fab_clk));

  assert_term_por_only_R4: assert property (@(posedge sys_clk) disable iff (por)
    (src_q < K_ACT) |-> !fab_rst);

  assert_act_sleep_rst_R5: assert property (@(posedge sys_clk) disable iff (por)
    (src_q == K_ACT && pm_mode != 2'b00) |-> fab_rst);

  assert_hib_rst_R6: assert property (@(posedge sys_clk) disable iff (por)
    ((src_q == K_DS || src_q == K_LF) && pm_mode[1]) |-> fab_rst);

  assert_disable_drops_R9: assert property (@(posedge sys_clk) disable iff (por)
    (cfg_wr && !cfg_en) |=> !fab_en);

  assert_no_en_in_rst_R10: assert property (@(posedge sys_clk) disable iff (por)
    fab_rst |-> !fab_en);
endmodule

bind fabric_clk_seq fabric_clk_seq_chk #(.N_TERM(N_TERM), .SRC_W(SRC_W)) u_chk (
  .sys_clk (sys_clk),
  .por     (por),
  .cfg_wr  (cfg_wr),
  .cfg_en  (cfg_en),
  .src_q   (src_q),
  .pm_mode (pm_mode),
  .fab_clk (fab_clk),
  .fab_en  (fab_en),
  .fab_rst (fab_rst),
  .cfg_err (cfg_err)
);

// File: tb/sim_fabric_clk_seq.sv
`timescale 1ns/1ps
module sim_fabric_clk_seq;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_src = '0;
  logic        cfg_en = 1'b0;
  logic [15:0] cfg_mask = '0;
  logic [1:0]  pm = 2'b00;
  logic [7:0]  io = '0;
  logic [7:0]  chip = '0;
  logic        dact = 1'b0, dds = 1'b0, dhib = 1'b0, lf = 1'b0;
  logic        fab_clk, fab_en, fab_rst, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_src = 0;
  bit m_en = 0;
  logic [15:0] m_mask = '0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  fabric_clk_seq u0 (
    .sys_clk(clk), .por(por), .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_en(cfg_en),
    .cfg_lut_mask(cfg_mask), .pm_mode(pm), .io_term(io), .chip_term(chip),
    .div_act_clk(dact), .div_ds_clk(dds), .div_hib_clk(dhib), .lf_clk(lf),
    .fab_clk(fab_clk), .fab_en(fab_en), .fab_rst(fab_rst), .cfg_err(cfg_err)
  );

  function automatic bit m_rst();
    return por || (m_src == 16 && pm != 2'b00) || ((m_src == 17 || m_src == 19) && pm[1]);
  endfunction
  function automatic int m_tgt();
    return (m_src == 20) ? 3 : 2;
  endfunction
  function automatic bit m_clk();
    if (m_src < 8) return io[m_src];
    if (m_src < 16) return chip[m_src - 8];
    case (m_src)
      16: return dact;
      17: return dds;
      18: return dhib;
      19: return lf;
      20: return clk;
      default: return 1'b0;
    endcase
  endfunction
  function automatic bit m_err();
    return (m_src > 20) || (m_src < 16 && m_mask[m_src]);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: configuration capture and system-clock counting
  always @(posedge clk) begin
    if (por) begin
      m_src = 0; m_en = 0; m_mask = '0; m_cnt = 0;
    end else begin
      if (m_src == 20 && m_en && !m_rst() && m_cnt < 3) m_cnt++;
      if (cfg_wr) begin
        m_src = int'(cfg_src); m_en = cfg_en; m_mask = cfg_mask;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      if (m_rst() || !m_en) m_cnt = 0;
      chk("R1", "fab_clk", 32'(fab_clk), 32'(m_clk()));
      chk("R7", "cfg_err", 32'(cfg_err), 32'(m_err()));
      chk("R5", "fab_rst", 32'(fab_rst), 32'(m_rst()));
      chk("R2", "fab_en", 32'(fab_en), 32'(m_en && !m_rst() && m_cnt >= m_tgt()));
    end
  end

  task automatic set_src(input int code, input logic v);
    if (code < 8) io[code] = v;
    else if (code < 16) chip[code - 8] = v;
    else case (code)
      16: dact = v;
      17: dds = v;
      18: dhib = v;
      default: lf = v;
    endcase
  endtask

  task automatic pulse(input int code);
    @(posedge clk); #1;
    set_src(code, 1'b1);
    if (code == m_src && m_en && !m_rst() && m_cnt < m_tgt()) m_cnt++;
    @(posedge clk); #1;
    set_src(code, 1'b0);
  endtask

  task automatic wr(input int code, input bit en, input logic [15:0] mask);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_src = 5'(code); cfg_en = en; cfg_mask = mask;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic set_pm(input logic [1:0] v);
    @(posedge clk); #1;
    pm = v;
  endtask

  task automatic arm(input int code);
    wr(code, 1'b0, 16'h0);
    wr(code, 1'b1, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-requirements act=timeout exp=finished");
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4", "reset fab_rst", 32'(fab_rst), 1);
    chk("R4", "reset fab_en", 32'(fab_en), 0);
    chk("R8", "reset cfg_err", 32'(cfg_err), 0);
    @(posedge clk); #1 por = 1'b0;

    // R2 terminal source, R10 other terminals ignored
    arm(3);
    pulse(3);
    @(negedge clk) chk("R2", "io3 after 1 edge", 32'(fab_en), 0);
    pulse(5);
    pulse(12);
    @(negedge clk) chk("R10", "unselected edges", 32'(fab_en), 0);
    pulse(3);
    @(negedge clk) chk("R2", "io3 after 2 edges", 32'(fab_en), 1);

    // R9 disable and restart
    wr(3, 1'b0, 16'h0);
    @(negedge clk) chk("R9", "disable fab_en", 32'(fab_en), 0);
    chk("R9", "disable no reset", 32'(fab_rst), 0);
    wr(3, 1'b1, 16'h0);
    pulse(3);
    @(negedge clk) chk("R9", "restart 1 edge", 32'(fab_en), 0);
    pulse(3);
    @(negedge clk) chk("R9", "restart 2 edges", 32'(fab_en), 1);

    // R7 terminal clash
    wr(3, 1'b0, 16'h0008);
    @(negedge clk) chk("R7", "io3 used as input", 32'(cfg_err), 1);
    wr(11, 1'b0, 16'h0800);
    @(negedge clk) chk("R7", "chip3 used as input", 32'(cfg_err), 1);
    wr(11, 1'b0, 16'h0008);
    @(negedge clk) chk("R7", "other terminal used", 32'(cfg_err), 0);

    // R3 asynchronous mode
    arm(20);
    repeat (2) @(posedge clk);
    @(negedge clk) chk("R3", "async 2 edges", 32'(fab_en), 0);
    @(posedge clk);
    @(negedge clk) chk("R3", "async 3 edges", 32'(fab_en), 1);
    set_pm(2'b10);
    @(negedge clk) chk("R4", "async hibernate", 32'(fab_rst), 0);
    set_pm(2'b00);

    // R5 and R8 active-class divided clock
    wr(20, 1'b0, 16'h0);
    arm(16);
    pulse(16); pulse(16);
    @(negedge clk) chk("R2", "div active 2 edges", 32'(fab_en), 1);
    set_pm(2'b01);
    @(negedge clk) chk("R5", "deep-sleep reset", 32'(fab_rst), 1);
    chk("R10", "en low in reset", 32'(fab_en), 0);
    set_pm(2'b00);
    @(negedge clk) chk("R5", "active no reset", 32'(fab_rst), 0);
    pulse(16); pulse(16);
    @(negedge clk) chk("R8", "re-enable without write", 32'(fab_en), 1);
    set_pm(2'b10);
    @(negedge clk) chk("R5", "hibernate reset", 32'(fab_rst), 1);

    // R10 edges during reset are lost
    set_pm(2'b01);
    pulse(16); pulse(16);
    set_pm(2'b00);
    @(negedge clk) chk("R10", "edges in reset lost", 32'(fab_en), 0);
    pulse(16);
    @(negedge clk) chk("R10", "count from zero", 32'(fab_en), 0);
    pulse(16);
    @(negedge clk) chk("R10", "count complete", 32'(fab_en), 1);

    // R6 deep-sleep class and low-frequency
    wr(16, 1'b0, 16'h0);
    arm(17);
    pulse(17); pulse(17);
    set_pm(2'b01);
    @(negedge clk) chk("R6", "ds clock in deep-sleep", 32'(fab_rst), 0);
    chk("R6", "ds clock keeps enable", 32'(fab_en), 1);
    set_pm(2'b10);
    @(negedge clk) chk("R6", "ds clock in hibernate", 32'(fab_rst), 1);
    set_pm(2'b00);
    wr(17, 1'b0, 16'h0);
    arm(19);
    set_pm(2'b11);
    @(negedge clk) chk("R6", "lf clock in hibernate", 32'(fab_rst), 1);
    set_pm(2'b00);
    pulse(19); pulse(19);
    @(negedge clk) chk("R2", "lf 2 edges", 32'(fab_en), 1);

    // R4 hibernate-class and chip terminal
    wr(19, 1'b0, 16'h0);
    arm(18);
    set_pm(2'b10);
    @(negedge clk) chk("R4", "hib clock in hibernate", 32'(fab_rst), 0);
    pulse(18); pulse(18);
    @(negedge clk) chk("R4", "hib clock runs", 32'(fab_en), 1);
    set_pm(2'b00);
    wr(18, 1'b0, 16'h0);
    arm(13);
    set_pm(2'b01);
    @(negedge clk) chk("R4", "chip terminal deep-sleep", 32'(fab_rst), 0);
    set_pm(2'b00);

    // R1 unassigned code
    wr(13, 1'b0, 16'h0);
    wr(25, 1'b1, 16'h0);
    pulse(16); pulse(19);
    @(negedge clk) chk("R1", "bad code err", 32'(cfg_err), 1);
    chk("R1", "bad code no enable", 32'(fab_en), 0);

    // R11 inputs ignored without strobe
    @(posedge clk); #1;
    cfg_src = 5'd3; cfg_en = 1'b0; cfg_mask = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) chk("R11", "no strobe err kept", 32'(cfg_err), 1);

    // R8 power-on reset clears configuration
    arm(16);
    pulse(16); pulse(16);
    @(negedge clk) chk("R8", "enabled before por", 32'(fab_en), 1);
    @(posedge clk); #1;
    por = 1'b1;
    m_src = 0; m_en = 0; m_mask = '0; m_cnt = 0;
    repeat (2) @(posedge clk); #1 por = 1'b0;
    pulse(16); pulse(16);
    @(negedge clk) chk("R8", "config cleared by por", 32'(fab_en), 0);
    chk("R8", "no reset after por", 32'(fab_rst), 0);

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule